// File: doc/BRIEF.md
# Dual-Port Parallel I/O with Byte/Word Width Modes

This block is a register-mapped parallel digital I/O unit with two 8-bit ports, A and B, reached over a small byte-wide host bus. Each port has its own direction setting. Its pins are modelled as separate input, output and output-enable vectors, so that the pad ring stays outside the block. A control register chooses between byte mode and word mode. In word mode the two ports act as one 16-bit port, and port A's direction setting governs both halves.

A request/acknowledge pair streams bytes through port A in byte mode. A peripheral strobe on port A marks a byte as captured when port A is an input, or as taken away when port A is an output. The request tells an external transfer engine that a byte is waiting or that the output latch is free. The request is the valid/ready handshake here: `dma_req` is the block's "ready/valid" and `dma_ack` is the engine's acceptance. The request stays high until an acknowledge is seen, and the engine may hold off as long as it likes. The peripheral strobe cannot be stalled, so a strobe that arrives before the previous byte was acknowledged overwrites the captured byte. In byte mode port B stays under plain register control the whole time.

Register writes take effect at the clock edge where `bus_wr` is sampled high. Reads are combinational from `bus_addr` and have no side effects.

Top module: `pio_dual_port`

## Requirements
- R1: After reset both ports are inputs (`pin_a_oe`=0, `pin_b_oe`=0), both output latches hold 0, the direction and control registers read 0, and `dma_req` is 0.
- R2: The direction register at address 2 holds port A's direction in bit 0 and port B's direction in bit 1 (1 = drive the pins). The output enables change at the edge that takes the write.
- R3: The control register at address 3 holds DMA enable in bit 0 and the width mode in bit 2 (0 = byte mode, 1 = word mode). Every other bit reads back 0.
- R4: In word mode `pin_b_oe` follows direction bit 0 and direction bit 1 is ignored. Bit 1 is still stored and read back.
- R5: A write to address 0 or 1 loads the port A or port B output latch. `pin_a_out` and `pin_b_out` always present their latches.
- R6: A read of address 0 or 1 returns the output latch when that port's effective direction is output. Otherwise it returns the pin value sampled at the previous edge. Addresses 4 to 7 read 0.
- R7: `dma_req` is high only when DMA enable is 1 and byte mode is selected. With port A as input it is high while a captured byte is pending. With port A as output it is high while the output latch is free. The latch counts as free after reset and after each strobe.
- R8: With port A as input, a `pin_a_stb` edge captures `pin_a_in` into `dma_rdata` and marks the byte pending. A strobe in the same cycle as an accepted acknowledge leaves the byte pending.
- R9: A `dma_ack` while `dma_req` is high is accepted. With port A as input it clears the pending byte. With port A as output it loads `dma_wdata` into the port A latch and marks the latch full. If a bus write to address 0 happens in the same cycle, the bus value wins the latch. A `dma_ack` while `dma_req` is low is ignored.
- R10: Transfers through port A never change port B's latch or output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_a_in | input | 8 | Port A pin inputs |
| pin_a_out | output | 8 | Port A output latch |
| pin_a_oe | output | 1 | Port A output enable |
| pin_a_stb | input | 1 | Port A peripheral strobe (capture or consume) |
| pin_b_in | input | 8 | Port B pin inputs |
| pin_b_out | output | 8 | Port B output latch |
| pin_b_oe | output | 1 | Port B output enable |
| dma_req | output | 1 | Transfer request |
| dma_ack | input | 1 | Transfer acknowledge |
| dma_wdata | input | 8 | Byte delivered into port A on an output acknowledge |
| dma_rdata | output | 8 | Captured port A byte for input transfers |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. One is a peripheral strobe that lands in the same cycle as an accepted acknowledge. Another is a bus write to port A that coincides with a DMA load. A third is a direction or mode change while a byte is pending. Directed phases first walk through clean input and output transfers. A long random phase then drives strobe, acknowledge, bus writes and mode bits independently every cycle, so these overlaps occur many times. A behavioural model compares every output on every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_PA  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PB  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_DIR = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CTL = 3'd3;

  localparam int DIR_A_BIT   = 0;
  localparam int DIR_B_BIT   = 1;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_WID_BIT = 2;

  localparam int NPORT = 2;

  typedef struct packed {
    logic dma_en;
    logic word;
  } ctl_t;
endpackage

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] out_q,
  output logic [W-1:0] smp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      smp_q <= '0;
    end else begin
      smp_q <= pin_in;
      if (ld) out_q <= ld_data;
    end
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [W-1:0]               wdata,
  input  logic [NPORT-1:0][W-1:0]    port_out,
  input  logic [NPORT-1:0][W-1:0]    port_smp,
  output logic                       dir_a,
  output logic                       dir_b_eff,
  output ctl_t                       ctl,
  output logic [W-1:0]               rdata
);
  logic dir_a_q, dir_b_q;
  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_a_q <= 1'b0;
      dir_b_q <= 1'b0;
      ctl_q   <= '0;
    end else if (wr) begin
      if (addr == REG_DIR) begin
        dir_a_q <= wdata[DIR_A_BIT];
        dir_b_q <= wdata[DIR_B_BIT];
      end
      if (addr == REG_CTL) begin
        ctl_q.dma_en <= wdata[CTL_EN_BIT];
        ctl_q.word   <= wdata[CTL_WID_BIT];
      end
    end
  end

  assign dir_a     = dir_a_q;
  assign dir_b_eff = ctl_q.word ? dir_a_q : dir_b_q;
  assign ctl       = ctl_q;

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_PA:  rdata = dir_a_q   ? port_out[0] : port_smp[0];
      REG_PB:  rdata = dir_b_eff ? port_out[1] : port_smp[1];
      REG_DIR: begin
        rdata[DIR_A_BIT] = dir_a_q;
        rdata[DIR_B_BIT] = dir_b_q;
      end
      REG_CTL: begin
        rdata[CTL_EN_BIT]  = ctl_q.dma_en;
        rdata[CTL_WID_BIT] = ctl_q.word;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_dma.sv
module pio_dma #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         to_pin,
  input  logic         stb,
  input  logic         ack,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] hold_q,
  output logic         req,
  output logic         load
);
  logic full_q, empty_q, take;

  assign req  = active && (to_pin ? empty_q : full_q);
  assign take = ack && req;
  assign load = take && to_pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      hold_q  <= '0;
    end else begin
      if (stb && !to_pin) begin
        full_q <= 1'b1;
        hold_q <= pin_in;
      end else if (take && !to_pin) begin
        full_q <= 1'b0;
      end
      if (take && to_pin)     empty_q <= 1'b0;
      else if (stb && to_pin) empty_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_a_in,
  output logic [W-1:0]      pin_a_out,
  output logic              pin_a_oe,
  input  logic              pin_a_stb,
  input  logic [W-1:0]      pin_b_in,
  output logic [W-1:0]      pin_b_out,
  output logic              pin_b_oe,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [W-1:0]      dma_wdata,
  output logic [W-1:0]      dma_rdata
);
  logic [NPORT-1:0][W-1:0] port_out, port_smp, ld_data, pin_in_v;
  logic [NPORT-1:0]        ld;
  logic                    dir_a, dir_b_eff, dma_load;
  ctl_t                    ctl;

  assign pin_in_v[0] = pin_a_in;
  assign pin_in_v[1] = pin_b_in;

  // bus write to port A has priority over a DMA load
  assign ld[0]      = (bus_wr && bus_addr == REG_PA) || dma_load;
  assign ld_data[0] = (bus_wr && bus_addr == REG_PA) ? bus_wdata : dma_wdata;
  assign ld[1]      = bus_wr && bus_addr == REG_PB;
  assign ld_data[1] = bus_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port #(.W(W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld[p]),
      .ld_data (ld_data[p]),
      .pin_in  (pin_in_v[p]),
      .out_q   (port_out[p]),
      .smp_q   (port_smp[p])
    );
  end

  pio_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .port_out  (port_out),
    .port_smp  (port_smp),
    .dir_a     (dir_a),
    .dir_b_eff (dir_b_eff),
    .ctl       (ctl),
    .rdata     (bus_rdata)
  );

  pio_dma #(.W(W)) u_dma (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (ctl.dma_en && !ctl.word),
    .to_pin (dir_a),
    .stb    (pin_a_stb),
    .ack    (dma_ack),
    .pin_in (pin_a_in),
    .hold_q (dma_rdata),
    .req    (dma_req),
    .load   (dma_load)
  );

  assign pin_a_out = port_out[0];
  assign pin_b_out = port_out[1];
  assign pin_a_oe  = dir_a;
  assign pin_b_oe  = dir_b_eff;
endmodule

// File: rtl/pio_dual_port_chk.sv
module pio_dual_port_chk
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pin_a_in,
  input logic [W-1:0]      pin_a_out,
  input logic              pin_a_oe,
  input logic              pin_a_stb,
  input logic [W-1:0]      pin_b_out,
  input logic              pin_b_oe,
  input logic              dma_req,
  input logic              dma_ack,
  input logic [W-1:0]      dma_rdata
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pin_a_oe && !pin_b_oe && !dma_req && pin_a_out == '0 && pin_b_out == '0));

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == REG_DIR) |=> $stable(pin_a_oe));

  assert_word_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_CTL && bus_wdata[CTL_WID_BIT]) |=> (pin_b_oe == pin_a_oe));

  assert_latch_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_PA) |=> (pin_a_out == $past(bus_wdata)));

  assert_dma_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_CTL && !bus_wdata[CTL_EN_BIT]) |=> !dma_req);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_a_stb && !pin_a_oe) |=> (dma_rdata == $past(pin_a_in)));

  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !pin_a_oe && !pin_a_stb && !bus_wr) |=> !dma_req);

  assert_b_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == REG_PB) |=> $stable(pin_b_out));
endmodule

bind pio_dual_port pio_dual_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .pin_a_in  (pin_a_in),
  .pin_a_out (pin_a_out),
  .pin_a_oe  (pin_a_oe),
  .pin_a_stb (pin_a_stb),
  .pin_b_out (pin_b_out),
  .pin_b_oe  (pin_b_oe),
  .dma_req   (dma_req),
  .dma_ack   (dma_ack),
  .dma_rdata (dma_rdata)
);

// File: tb/sim_pio_dual_port.sv
`timescale 1ns/1ps
module sim_pio_dual_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_a_in = '0, pin_b_in = '0, dma_wdata = '0;
  logic [7:0] pin_a_out, pin_b_out, dma_rdata;
  logic       pin_a_oe, pin_b_oe, dma_req;
  logic       pin_a_stb = 1'b0, dma_ack = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pio_dual_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_a_in(pin_a_in),
    .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe), .pin_a_stb(pin_a_stb),
    .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata)
  );

  // behavioural reference state
  bit       m_da, m_db, m_en, m_word, m_full, m_empty;
  bit [7:0] m_oa, m_ob, m_sa, m_sb, m_hold;

  function automatic bit m_req();
    return m_en && !m_word && (m_da ? m_empty : m_full);
  endfunction

  function automatic bit [7:0] m_read(input bit [2:0] a);
    bit db;
    db = m_word ? m_da : m_db;
    case (a)
      3'd0: return m_da ? m_oa : m_sa;
      3'd1: return db ? m_ob : m_sb;
      3'd2: return {6'd0, m_db, m_da};
      3'd3: return {5'd0, m_word, 1'b0, m_en};
      default: return 8'd0;
    endcase
  endfunction

  task automatic m_update();
    bit take;
    if (!rst_n) begin
      m_da = 0; m_db = 0; m_en = 0; m_word = 0; m_full = 0; m_empty = 1;
      m_oa = 0; m_ob = 0; m_sa = 0; m_sb = 0; m_hold = 0;
      return;
    end
    take = dma_ack && m_req();
    if (pin_a_stb && !m_da) begin m_full = 1; m_hold = pin_a_in; end
    else if (take && !m_da) m_full = 0;
    if (take && m_da) begin m_empty = 0; m_oa = dma_wdata; end
    else if (pin_a_stb && m_da) m_empty = 1;
    if (bus_wr) begin
      case (bus_addr)
        3'd0: m_oa = bus_wdata;
        3'd1: m_ob = bus_wdata;
        3'd2: begin m_da = bus_wdata[0]; m_db = bus_wdata[1]; end
        3'd3: begin m_en = bus_wdata[0]; m_word = bus_wdata[2]; end
        default: ;
      endcase
    end
    m_sa = pin_a_in;
    m_sb = pin_b_in;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 pin_a_oe", {7'd0, pin_a_oe}, {7'd0, m_da});
    check("R4 pin_b_oe", {7'd0, pin_b_oe}, {7'd0, (m_word ? m_da : m_db)});
    check("R5 pin_a_out", pin_a_out, m_oa);
    check("R10 pin_b_out", pin_b_out, m_ob);
    check("R7 dma_req", {7'd0, dma_req}, {7'd0, m_req()});
    check("R8 dma_rdata", dma_rdata, m_hold);
    check("R6 bus_rdata", bus_rdata, m_read(bus_addr));
  endtask

  task automatic cyc();
    @(posedge clk);
    m_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    bus_wr = 0; pin_a_stb = 0; dma_ack = 0;
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cyc(); bus_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input bit [2:0] a, input bit [7:0] exp);
    idle(); bus_addr = a; #1; check(tag, bus_rdata, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_update();
    repeat (3) cyc();
    rst_n = 1;
    @(negedge clk);
    // R1: reset values at the ports
    rd_chk("R1 dir reg", 3'd2, 8'h00);
    rd_chk("R1 ctl reg", 3'd3, 8'h00);
    check("R1 oe", {6'd0, pin_a_oe, pin_b_oe}, 8'h00);
    check("R1 req", {7'd0, dma_req}, 8'h00);

    // R6: input sampling, one edge late
    pin_a_in = 8'h3c; pin_b_in = 8'hc3; cyc();
    rd_chk("R6 sample A", 3'd0, 8'h3c);
    rd_chk("R6 sample B", 3'd1, 8'hc3);
    rd_chk("R6 unused addr", 3'd6, 8'h00);

    // R2/R5: outputs
    wr(3'd0, 8'h5a); wr(3'd1, 8'ha5); wr(3'd2, 8'h03);
    rd_chk("R5 read back A", 3'd0, 8'h5a);
    rd_chk("R3 ctl other bits", 3'd3, 8'h00);
    wr(3'd3, 8'hff);
    rd_chk("R3 ctl masked", 3'd3, 8'h05);

    // R4: word mode, B direction bit ignored
    wr(3'd2, 8'h01);
    check("R4 b follows a", {7'd0, pin_b_oe}, 8'h01);
    rd_chk("R4 dir stored", 3'd2, 8'h01);
    wr(3'd2, 8'h02);
    check("R4 b follows a low", {7'd0, pin_b_oe}, 8'h00);
    check("R7 no req in word", {7'd0, dma_req}, 8'h00);

    // R7/R8/R9: byte-mode input transfer
    wr(3'd3, 8'h01); wr(3'd2, 8'h02);
    check("R7 idle input", {7'd0, dma_req}, 8'h00);
    pin_a_in = 8'h77; pin_a_stb = 1; cyc(); pin_a_stb = 0;
    check("R8 captured", dma_rdata, 8'h77);
    check("R7 pending", {7'd0, dma_req}, 8'h01);
    repeat (3) cyc();
    dma_ack = 1; cyc(); dma_ack = 0;
    check("R9 cleared", {7'd0, dma_req}, 8'h00);
    dma_ack = 1; cyc(); dma_ack = 0;
    check("R9 stray ack", {7'd0, dma_req}, 8'h00);

    // R9/R10: output transfer
    wr(3'd2, 8'h03);
    check("R7 latch free", {7'd0, dma_req}, 8'h01);
    dma_wdata = 8'he1; dma_ack = 1; cyc(); dma_ack = 0;
    check("R9 loaded", pin_a_out, 8'he1);
    check("R10 b kept", pin_b_out, 8'ha5);
    pin_a_stb = 1; cyc(); pin_a_stb = 0;
    check("R7 free again", {7'd0, dma_req}, 8'h01);
    bus_addr = 3'd0; bus_wdata = 8'h12; bus_wr = 1; dma_wdata = 8'h34; dma_ack = 1;
    cyc(); idle();
    check("R9 bus wins latch", pin_a_out, 8'h12);
    check("R9 empty cleared", {7'd0, dma_req}, 8'h00);

    // random collisions, compared every clock
    for (int i = 0; i < 3000; i++) begin
      bus_wr    = ($urandom % 4) == 0;
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
      pin_a_in  = 8'($urandom);
      pin_b_in  = 8'($urandom);
      pin_a_stb = ($urandom % 3) == 0;
      dma_ack   = ($urandom % 2) == 0;
      dma_wdata = 8'($urandom);
      if (bus_addr == 3'd3 && bus_wr) bus_wdata[2] = ($urandom % 4) == 0;
      cyc();
    end
    idle();
    cyc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule